// File: doc/BRIEF.md
# Predicated Vector Compare Unit

This block takes a conditional-branch-format instruction word and, instead of branching, runs an element-wise comparison between two vector register operands. For each element index it produces one predicate bit and writes that bit into a predicate destination register. The register number of that destination comes from the field that would otherwise hold the low branch offset.

The unit reads the vector length of each source from a flat per-register length bus when the instruction starts. It then walks the elements one per clock through two combinational element read ports. Each result is emitted as a single-bit write carrying the register, the bit position and the value. The storage that receives the write keeps every bit that is not written.

Integer compares may be signed or unsigned. Float compares use IEEE bit patterns ordered by a sign-magnitude rule, so there is no real floating-point arithmetic. An unsupported code is reported as illegal and nothing is written.

Top module: `pred_cmp_unit`

## Requirements
- R1: Instruction fields are decoded as follows:
  - src1 register from bits 19:15 and src2 register from bits 24:20.
  - compare code from bits 14:12 and the integer/float select from bit 31 (1 = float).
  - predicate destination register from bits 11:7.
  - bits 30:25 are ignored.
  - bits 6:0 must equal 7'b1100011.
- R2: Integer compare codes are 000 a==b, 001 a!=b, 100 signed a<=b, 101 signed a>=b, 110 unsigned a<b and 111 unsigned a>=b. Here a is the src1 element and b is the src2 element.
- R3: Float compare codes are 000 bitwise equal, 001 bitwise not equal, 100 a<b and 101 a<=b. Ordering follows these rules:
  - a negative pattern (sign bit set) is below a positive one.
  - two positive patterns are ordered by their magnitude bits.
  - two negative patterns are ordered inversely by their magnitude bits, so -0 is below +0.
- R4: A source whose vector length is 0 or 1 is a scalar. Its element 0 is read for every element index, which shows up as a read index of 0.
- R5: The number of element writes n is the larger of the two vector lengths, capped at XLEN. Writes go to bits 0..n-1 in ascending order, one per clock, starting in the cycle after start. No other bit is written.
- R6: These cases pulse `illegal` for one cycle in the cycle after start, with no write and no `done`:
  - integer codes 010 and 011.
  - float codes 010, 011, 110 and 111.
  - a wrong major opcode.
- R7: `done` is high for exactly one cycle, in the cycle after the last write. When n is 0 it is high in the cycle after start.
- R8: `start` is ignored while `busy` is high.
- R9: After reset, `busy`, `done`, `illegal` and `pw_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the instruction when idle |
| instr | input | 32 | Branch-format compare instruction |
| vlens | input | NREG*VLW | Vector length of each register, register r at bits r*VLW upward |
| ra_reg | output | 5 | src1 read register |
| ra_idx | output | 5 | src1 element index |
| ra_data | input | XLEN | src1 element value (same cycle) |
| rb_reg | output | 5 | src2 read register |
| rb_idx | output | 5 | src2 element index |
| rb_data | input | XLEN | src2 element value (same cycle) |
| pw_en | output | 1 | Predicate bit write strobe |
| pw_reg | output | 5 | Predicate destination register |
| pw_bit | output | 5 | Bit position written |
| pw_val | output | 1 | Compare result |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle reserved-encoding pulse |

## Verification
The assertions assume that `start` arrives either while the unit is idle or as a deliberately ignored pulse during a run. They also assume that the element read ports answer in the same cycle. The bench drives `start` only on falling edges and returns read data combinationally from a fixed function of register and index.

The sweep covers every compare code in both integer and float modes. It combines them with vector-vs-vector, scalar-on-either-side, zero-length and over-cap length settings. The operand table mixes signed extremes, both zeros and infinities, so the sign-magnitude ordering and the signed/unsigned split are both stressed.

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int VLW  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [31:0]           instr,
  input  logic [NREG*VLW-1:0]   vlens,
  output logic [4:0]            ra_reg,
  output logic [$clog2(XLEN)-1:0] ra_idx,
  input  logic [XLEN-1:0]       ra_data,
  output logic [4:0]            rb_reg,
  output logic [$clog2(XLEN)-1:0] rb_idx,
  input  logic [XLEN-1:0]       rb_data,
  output logic                  pw_en,
  output logic [4:0]            pw_reg,
  output logic [$clog2(XLEN)-1:0] pw_bit,
  output logic                  pw_val,
  output logic                  busy,
  output logic                  done,
  output logic                  illegal
);
  localparam int BW = $clog2(XLEN);
  localparam int IW = $clog2(XLEN + 1);
  localparam int CW = (VLW > IW) ? VLW : IW;
  localparam logic [6:0] OPC = 7'b1100011;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic          is_f, sc1, sc2, ill_q;
  logic [2:0]    f3;
  logic [4:0]    s1, s2, pd;
  logic [CW-1:0] idx, n_q;

  wire        d_isf = instr[31];
  wire [2:0]  d_f3  = instr[14:12];
  wire [4:0]  d_s1  = instr[19:15];
  wire [4:0]  d_s2  = instr[24:20];
  wire [4:0]  d_pd  = instr[11:7];

  logic [VLW-1:0] vl1, vl2;
  logic [CW-1:0]  mx, cnt;
  logic           legal;

  always_comb begin
    vl1 = vlens[32'(d_s1)*VLW +: VLW];
    vl2 = vlens[32'(d_s2)*VLW +: VLW];
    mx  = (vl1 > vl2) ? CW'(vl1) : CW'(vl2);
    cnt = (mx > CW'(XLEN)) ? CW'(XLEN) : mx;
    if (instr[6:0] != OPC) legal = 1'b0;
    else if (d_isf) legal = (d_f3 == 3'b000) || (d_f3 == 3'b001) ||
                            (d_f3 == 3'b100) || (d_f3 == 3'b101);
    else legal = (d_f3 != 3'b010) && (d_f3 != 3'b011);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ill_q <= 1'b0;
      idx   <= '0;
      n_q   <= '0;
      is_f  <= 1'b0;
      f3    <= '0;
      s1    <= '0;
      s2    <= '0;
      pd    <= '0;
      sc1   <= 1'b0;
      sc2   <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!legal) ill_q <= 1'b1;
          else begin
            is_f <= d_isf;
            f3   <= d_f3;
            s1   <= d_s1;
            s2   <= d_s2;
            pd   <= d_pd;
            sc1  <= (vl1 <= VLW'(1));
            sc2  <= (vl2 <= VLW'(1));
            idx  <= '0;
            n_q  <= cnt;
            st   <= (cnt == '0) ? S_FIN : S_RUN;
          end
        end
        S_RUN: begin
          idx <= idx + 1'b1;
          if (idx + 1'b1 == n_q) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  localparam logic [XLEN-1:0] SGN = {1'b1, {(XLEN-1){1'b0}}};
  wire [XLEN-1:0] ka = ra_data[XLEN-1] ? ~ra_data : (ra_data ^ SGN);
  wire [XLEN-1:0] kb = rb_data[XLEN-1] ? ~rb_data : (rb_data ^ SGN);
  wire eq  = (ra_data == rb_data);
  wire slt = $signed(ra_data) < $signed(rb_data);
  wire ult = ra_data < rb_data;
  wire flt = ka < kb;

  logic res;
  always_comb begin
    if (is_f) begin
      case (f3)
        3'b000:  res = eq;
        3'b001:  res = !eq;
        3'b100:  res = flt;
        default: res = flt || eq;
      endcase
    end else begin
      case (f3)
        3'b000:  res = eq;
        3'b001:  res = !eq;
        3'b100:  res = slt || eq;
        3'b101:  res = !slt;
        3'b110:  res = ult;
        default: res = !ult;
      endcase
    end
  end

  assign ra_reg  = s1;
  assign rb_reg  = s2;
  assign ra_idx  = sc1 ? '0 : idx[BW-1:0];
  assign rb_idx  = sc2 ? '0 : idx[BW-1:0];
  assign pw_en   = (st == S_RUN);
  assign pw_reg  = pd;
  assign pw_bit  = idx[BW-1:0];
  assign pw_val  = res;
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign illegal = ill_q;
endmodule

module pred_cmp_unit_chk #(
  parameter int BW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pw_en,
  input logic [BW-1:0] pw_bit,
  input logic          busy,
  input logic          done,
  input logic          illegal
);
  a_r5_ascending_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && $past(pw_en)) |-> (pw_bit == $past(pw_bit) + 1'b1));
  a_r5_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && pw_en) |-> (pw_bit == '0));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pw_en) && !pw_en) |-> done);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!pw_en && !done && !busy));
  a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pw_en);
endmodule

bind pred_cmp_unit pred_cmp_unit_chk #(.BW($clog2(XLEN))) chk_i (
  .clk(clk), .rst_n(rst_n), .pw_en(pw_en), .pw_bit(pw_bit),
  .busy(busy), .done(done), .illegal(illegal));

// File: tb/pred_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module pred_cmp_unit_tb_top;
  localparam int XLEN = 32, NREG = 32, VLW = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] instr = '0;
  logic [NREG*VLW-1:0] vlens = '0;
  logic [4:0] ra_reg, rb_reg, pw_reg, ra_idx, rb_idx, pw_bit;
  logic [XLEN-1:0] ra_data, rb_data;
  logic pw_en, pw_val, busy, done, illegal;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pred_cmp_unit #(.XLEN(XLEN), .NREG(NREG), .VLW(VLW)) dut_i (.*);

  function automatic logic [31:0] elem(input logic [4:0] r, input logic [4:0] i);
    logic [31:0] t [8];
    t = '{32'h0, 32'h8000_0000, 32'h1, 32'hFFFF_FFFF,
          32'h7F80_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h7FFF_FFFF};
    return t[(32'(r) * 3 + 32'(i)) % 8];
  endfunction

  assign ra_data = elem(ra_reg, ra_idx);
  assign rb_data = elem(rb_reg, rb_idx);

  function automatic logic fless(input logic [31:0] a, input logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  function automatic logic expect_cmp(input logic isf, input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    if (isf) begin
      case (f)
        3'd0: return a == b;
        3'd1: return a != b;
        3'd4: return fless(a, b);
        default: return fless(a, b) || a == b;
      endcase
    end
    case (f)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) <= $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic isf, input logic [2:0] f, input logic [6:0] opc,
                        input int v1, input int v2, input int k, input logic busy_poke);
    logic [4:0] s1, s2, pd;
    logic legal;
    int n, writes, done_cyc;
    s1 = 5'(3 + k % 5);
    s2 = 5'(32'(s1) + 8 + k % 4);
    pd = 5'(17 + k % 7);
    vlens = '0;
    vlens[32'(s1)*VLW +: VLW] = VLW'(v1);
    vlens[32'(s2)*VLW +: VLW] = VLW'(v2);
    legal = (opc == 7'b1100011) &&
            (isf ? (f == 0 || f == 1 || f == 4 || f == 5) : (f != 2 && f != 3));
    n = (v1 > v2) ? v1 : v2;
    if (n > XLEN) n = XLEN;
    @(negedge clk);
    instr = {isf, (k % 2 == 1) ? 6'b101101 : 6'b0, s2, s1, f, pd, opc};
    start = 1;
    @(negedge clk);
    start = 0;
    writes = 0;
    done_cyc = -1;
    for (int cyc = 0; cyc < 45; cyc++) begin
      if (!legal) begin
        if (cyc == 0) chk(illegal === 1'b1, "R6 illegal pulse", int'(illegal), 1);
        else chk(illegal === 1'b0, "R6 illegal single", int'(illegal), 0);
        chk(!pw_en && !done, "R6 no write/done", int'(pw_en) + int'(done), 0);
      end else begin
        chk(illegal === 1'b0, "R8 no illegal on legal run", int'(illegal), 0);
        if (busy_poke && cyc == 2) begin
          instr = 32'h0000_0000; start = 1;
        end else start = 0;
        if (pw_en) begin
          logic [31:0] a, b;
          a = elem(s1, (v1 <= 1) ? 5'd0 : 5'(writes));
          b = elem(s2, (v2 <= 1) ? 5'd0 : 5'(writes));
          chk(pw_bit == 5'(writes), "R5 bit order", int'(pw_bit), writes);
          chk(pw_reg == pd && ra_reg == s1 && rb_reg == s2, "R1 field decode", int'(pw_reg), int'(pd));
          if (v1 <= 1) chk(ra_idx == 0, "R4 scalar src1 idx", int'(ra_idx), 0);
          if (v2 <= 1) chk(rb_idx == 0, "R4 scalar src2 idx", int'(rb_idx), 0);
          chk(pw_val == expect_cmp(isf, f, a, b), isf ? "R3 float compare" : "R2 int compare",
              int'(pw_val), int'(expect_cmp(isf, f, a, b)));
          writes++;
        end
        if (done && done_cyc < 0) done_cyc = cyc;
      end
      @(negedge clk);
    end
    start = 0;
    if (legal) begin
      chk(writes == n, "R5 write count", writes, n);
      chk(done_cyc == n, "R7 done timing", done_cyc, n);
    end
    chk(!busy && !done, "R7 idle after op", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !pw_en, "R9 reset state", int'(busy), 0);
    rst_n = 1;
    for (int op = 0; op < 16; op++) begin
      run_op(op[3], op[2:0], 7'b1100011, 4, 4, op, 1'b0);
      run_op(op[3], op[2:0], 7'b1100011, 1, 6, op + 1, 1'b0);
      run_op(op[3], op[2:0], 7'b1100011, 7, 0, op + 2, 1'b0);
      run_op(op[3], op[2:0], 7'b1100011, 40, 3, op + 3, op == 0);
      run_op(op[3], op[2:0], 7'b1100011, 0, 0, op + 4, 1'b0);
    end
    run_op(1'b0, 3'd0, 7'b0110011, 4, 4, 5, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule